// File: doc/BRIEF.md
# Parallel Prefix Carry Adder

This block is a purely combinational N-bit binary adder. It takes two unsigned operands and a carry input, and it returns an N-bit sum and a carry output. N is a power of two, and its default is 16. The carries are not rippled from column to column. Every column's incoming carry comes out of a logarithmic tree of generate/propagate merge cells. The tree is written as explicit levels, so it makes no use of a behavioural addition operator.

The carry input enters the tree as an extra column below bit 0. That column generates the carry-in and never propagates. As a result, the carry into column i is the merged generate of the span from column i-1 down to that extra column. The tree has log2(N) levels, and each level doubles the span that each entry covers. Entries whose span already reaches the bottom pass through a level unchanged. One further merge cell above the top column forms the carry output.

The block holds no state and needs no clock or reset. It is meant to sit inside a datapath wherever a short adder carry path matters.

Top module: `pfx_carry_adder`

## Requirements
- R1: `{carry_out, sum_out}` equals `op_a + op_b + carry_in`, taken as an (N+1)-bit unsigned value, for the default N=16.
- R2: With `carry_in`=0 the outputs equal the plain unsigned sum `op_a + op_b`.
- R3: `op_a` all ones, `op_b`=0 and `carry_in`=1 give `sum_out`=0 and `carry_out`=1. In this case the carry-in passes through every column.
- R4: When `op_a ^ op_b` is all ones, every column only propagates. `carry_out` then equals `carry_in`. `sum_out` is all ones for `carry_in`=0 and zero for `carry_in`=1.
- R5: When `op_a | op_b` is zero, `sum_out` equals `carry_in` in bit 0 and zero elsewhere, and `carry_out` is 0.
- R6: When bit N-1 of both operands is 1, `carry_out` is 1 whatever the other inputs are.
- R7: `sum_out[0]` equals `op_a[0] ^ op_b[0] ^ carry_in`.
- R8: The same structure is correct for other power-of-two widths. With N=4, all 512 combinations of the inputs give `op_a + op_b + carry_in`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | N | First unsigned operand |
| op_b | input | N | Second unsigned operand |
| carry_in | input | 1 | Carry into bit 0 |
| sum_out | output | N | Low N bits of the sum |
| carry_out | output | 1 | Carry out of bit N-1 |

## Verification
The case that is hardest to reach by chance is a carry that starts at the carry input and must cross every column. It only happens when every operand bit pair propagates. Uniform random operands at N=16 almost never produce it. The stimulus therefore forces it in two ways. It drives the directed pattern of all ones plus zero with a carry-in. It also draws random operand pairs whose bitwise XOR is all ones, which exercises the whole-chain propagate path and its last merge cell. The N=4 instance is run exhaustively, so it covers every partial carry chain at that width.

// File: rtl/pfx_adder_pkg.sv
// Shared helpers for the prefix adder.
// The merge rules assume the upper span sits directly above the lower span.
package pfx_adder_pkg;

    // Generate of a span made from an upper span and the adjoining lower span
    function automatic logic merge_g(input logic hi_g, input logic hi_p, input logic lo_g);
        return hi_g | (hi_p & lo_g);
    endfunction

    // Propagate of a span made from two adjoining spans
    function automatic logic merge_p(input logic hi_p, input logic lo_p);
        return hi_p & lo_p;
    endfunction

endpackage

// File: rtl/pfx_column_pg.sv
// Column generate/propagate stage.
// Entry 0 is the extra column below bit 0: it generates carry_in and never propagates.
// Entry i (i >= 1) describes operand column i-1. The top column's pair goes out separately,
// and so does the half sum of every column.
// Assumes N >= 2.
module pfx_column_pg #(
    parameter int N = 16
) (
    input  logic [N-1:0] op_a,
    input  logic [N-1:0] op_b,
    input  logic         carry_in,
    output logic [N-1:0] col_g,
    output logic [N-1:0] col_p,
    output logic         top_g,
    output logic         top_p,
    output logic [N-1:0] half_sum
);

    // Carry-in column at entry 0
    assign col_g[0] = carry_in;
    assign col_p[0] = 1'b0;

    // Operand columns 0..N-2 at entries 1..N-1
    for (genvar i = 1; i < N; i++) begin : g_col
        assign col_g[i] = op_a[i-1] & op_b[i-1];
        assign col_p[i] = op_a[i-1] | op_b[i-1];
    end

    // Top operand column pair, used only by the carry-out cell
    assign top_g    = op_a[N-1] & op_b[N-1];
    assign top_p    = op_a[N-1] | op_b[N-1];

    // Per-column XOR for the sum bits
    assign half_sum = op_a ^ op_b;

endmodule

// File: rtl/pfx_merge_cell.sv
// One generate/propagate merge cell of the prefix tree.
// Assumes the hi inputs describe the span directly above the lo span.
module pfx_merge_cell
    import pfx_adder_pkg::*;
(
    input  logic hi_g,
    input  logic hi_p,
    input  logic lo_g,
    input  logic lo_p,
    output logic out_g,
    output logic out_p
);

    // Merge the two adjoining spans into one
    assign out_g = merge_g(hi_g, hi_p, lo_g);
    assign out_p = merge_p(hi_p, lo_p);

endmodule

// File: rtl/pfx_prefix_tree.sv
// Logarithmic prefix tree over N entries, with entry 0 being the carry-in column.
// At level l, entry k merges with entry k - 2^l when k >= 2^l. Otherwise its span already
// reaches entry 0 and it passes through unchanged. After log2(N) levels, pre_g[k] is the
// generate of the span from entry k down to entry 0, which is the carry into operand column k.
// On the last level only the generate is formed, because no later level reads the propagate.
// Assumes N is a power of two and at least 2.
module pfx_prefix_tree
    import pfx_adder_pkg::*;
#(
    parameter int N = 16
) (
    input  logic [N-1:0] col_g,
    input  logic [N-1:0] col_p,
    output logic [N-1:0] pre_g
);

    localparam int LVLS = $clog2(N);

    logic [N-1:0] lvl_g [0:LVLS];
    logic [N-1:0] lvl_p [0:LVLS-1];

    // Level 0 inputs are the column pairs
    assign lvl_g[0] = col_g;
    assign lvl_p[0] = col_p;

    for (genvar l = 0; l < LVLS; l++) begin : g_lvl
        localparam int DIST = 1 << l;
        for (genvar k = 0; k < N; k++) begin : g_ent
            if (k < DIST) begin : g_pass
                // Span already reaches entry 0
                assign lvl_g[l+1][k] = lvl_g[l][k];
                if (l < LVLS - 1) begin : g_pp
                    assign lvl_p[l+1][k] = lvl_p[l][k];
                end
            end else if (l < LVLS - 1) begin : g_cell
                // Full merge cell, both terms needed later
                pfx_merge_cell u_cell (
                    .hi_g  (lvl_g[l][k]),
                    .hi_p  (lvl_p[l][k]),
                    .lo_g  (lvl_g[l][k-DIST]),
                    .lo_p  (lvl_p[l][k-DIST]),
                    .out_g (lvl_g[l+1][k]),
                    .out_p (lvl_p[l+1][k])
                );
            end else begin : g_last
                // Last level: only the generate is consumed
                assign lvl_g[l+1][k] = merge_g(lvl_g[l][k], lvl_p[l][k], lvl_g[l][k-DIST]);
            end
        end
    end

    assign pre_g = lvl_g[LVLS];

endmodule

// File: rtl/pfx_carry_adder.sv
// Top of the parallel prefix adder. It is purely combinational, so it holds no state
// and needs neither clock nor reset.
// Sum bit i is the column XOR with the prefix carry into column i. The carry out comes from
// one extra merge of the top column with the full prefix below it.
// Assumes N is a power of two and at least 2.
module pfx_carry_adder
    import pfx_adder_pkg::*;
#(
    parameter int N = 16
) (
    input  logic [N-1:0] op_a,
    input  logic [N-1:0] op_b,
    input  logic         carry_in,
    output logic [N-1:0] sum_out,
    output logic         carry_out
);

    logic [N-1:0] col_g;
    logic [N-1:0] col_p;
    logic [N-1:0] half_sum;
    logic [N-1:0] pre_g;
    logic         top_g;
    logic         top_p;

    // Column generate/propagate, with the carry-in as the bottom entry
    pfx_column_pg #(.N(N)) u_cols (
        .op_a     (op_a),
        .op_b     (op_b),
        .carry_in (carry_in),
        .col_g    (col_g),
        .col_p    (col_p),
        .top_g    (top_g),
        .top_p    (top_p),
        .half_sum (half_sum)
    );

    // Prefix carries into every column
    pfx_prefix_tree #(.N(N)) u_tree (
        .col_g (col_g),
        .col_p (col_p),
        .pre_g (pre_g)
    );

    // Sum bits from the column XOR and the incoming carry
    assign sum_out   = half_sum ^ pre_g;

    // Extra merge above the top column for the carry out
    assign carry_out = merge_g(top_g, top_p, pre_g[N-1]);

endmodule

// File: rtl/pfx_carry_adder_chk.sv
// Assertion checker for pfx_carry_adder, attached by bind.
// The block is combinational, so the checks are immediate assertions on settled values.
module pfx_carry_adder_chk #(
    parameter int N = 16
) (
    input logic [N-1:0] op_a,
    input logic [N-1:0] op_b,
    input logic         carry_in,
    input logic [N-1:0] sum_out,
    input logic         carry_out
);

    logic [N:0] ref_total;
    assign ref_total = {1'b0, op_a} + {1'b0, op_b} + {{N{1'b0}}, carry_in};

    // Output relations against input patterns
    always_comb begin
        AST_SUM_MATCH: assert ({carry_out, sum_out} == ref_total); // R1
        if (&(op_a ^ op_b)) begin
            AST_FULL_PROPAGATE: assert (carry_out == carry_in && sum_out == {N{~carry_in}}); // R4
        end
        if ((op_a | op_b) == '0) begin
            AST_NO_ACTIVITY: assert (carry_out == 1'b0 && sum_out == {{(N-1){1'b0}}, carry_in}); // R5
        end
        if (op_a[N-1] && op_b[N-1]) begin
            AST_TOP_GENERATE: assert (carry_out); // R6
        end
        AST_LSB_SUM: assert (sum_out[0] == (op_a[0] ^ op_b[0] ^ carry_in)); // R7
    end

endmodule

bind pfx_carry_adder pfx_carry_adder_chk #(.N(N)) u_chk (
    .op_a      (op_a),
    .op_b      (op_b),
    .carry_in  (carry_in),
    .sum_out   (sum_out),
    .carry_out (carry_out)
);

// File: tb/tb_pfx_carry_adder.sv
// Bench for pfx_carry_adder: a 16-bit instance under random and directed stimulus,
// and a 4-bit instance under exhaustive stimulus.
module tb_pfx_carry_adder;

    localparam int W  = 16;
    localparam int WS = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;   // 250 MHz

    logic [W-1:0]  a, b, s;
    logic          ci, co;
    logic [WS-1:0] as4, bs4, ss4;
    logic          ci4, co4;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    pfx_carry_adder #(.N(W)) dut (
        .op_a(a), .op_b(b), .carry_in(ci), .sum_out(s), .carry_out(co)
    );

    pfx_carry_adder #(.N(WS)) dut_n4 (
        .op_a(as4), .op_b(bs4), .carry_in(ci4), .sum_out(ss4), .carry_out(co4)
    );

    // Reference (N+1)-bit totals, computed from the requirements
    function automatic logic [W:0] ref16(input logic [W-1:0] x, input logic [W-1:0] y, input logic c);
        return {1'b0, x} + {1'b0, y} + {{W{1'b0}}, c};
    endfunction

    function automatic logic [WS:0] ref4(input logic [WS-1:0] x, input logic [WS-1:0] y, input logic c);
        return {1'b0, x} + {1'b0, y} + {{WS{1'b0}}, c};
    endfunction

    // Drive the 16-bit instance after a rising edge, then compare at the falling edge
    task automatic run16(input logic [W-1:0] x, input logic [W-1:0] y, input logic c,
                         input logic [W:0] exp_v, input string req);
        @(posedge clk);
        a <= x; b <= y; ci <= c;
        @(negedge clk);
        checks++;
        if ({co, s} !== exp_v) begin
            errors++;
            $display("FAIL %s: a=%h b=%h ci=%0b actual=%h expected=%h", req, x, y, c, {co, s}, exp_v);
        end
    endtask

    // Same for the 4-bit instance
    task automatic run4(input logic [WS-1:0] x, input logic [WS-1:0] y, input logic c);
        @(posedge clk);
        as4 <= x; bs4 <= y; ci4 <= c;
        @(negedge clk);
        checks++;
        if ({co4, ss4} !== ref4(x, y, c)) begin
            errors++;
            $display("FAIL R8: a=%h b=%h ci=%0b actual=%h expected=%h", x, y, c, {co4, ss4}, ref4(x, y, c));
        end
    endtask

    // Watchdog: a run that hangs counts as a failed check
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] x, y;
        logic c;
        void'($urandom(32'h5eed_1234));
        a = '0; b = '0; ci = 1'b0;
        as4 = '0; bs4 = '0; ci4 = 1'b0;
        repeat (3) @(posedge clk);
        rst_n <= 1'b1;

        // Initial state: zero inputs must give zero outputs (R5)
        @(negedge clk);
        checks++;
        if ({co, s} !== '0) begin
            errors++;
            $display("FAIL R5 init: actual=%h expected=0", {co, s});
        end

        // Directed corner cases
        run16('1, '0, 1'b1, {1'b1, {W{1'b0}}}, "R3");                 // carry crosses every column
        run16('0, '1, 1'b1, {1'b1, {W{1'b0}}}, "R3");
        run16(16'hAAAA, 16'h5555, 1'b0, {1'b0, {W{1'b1}}}, "R4");      // all propagate, no carry
        run16(16'hAAAA, 16'h5555, 1'b1, {1'b1, {W{1'b0}}}, "R4");
        run16('0, '0, 1'b1, {{W{1'b0}}, 1'b1}, "R5");
        run16('0, '0, 1'b0, '0, "R5");
        run16(16'h8000, 16'h8000, 1'b0, {1'b1, {W{1'b0}}}, "R6");      // top column generates
        run16('1, '1, 1'b1, {1'b1, {W{1'b1}}}, "R1");
        run16(16'h0001, 16'h0000, 1'b1, 17'h00002, "R7");
        run16(16'h1234, 16'h4321, 1'b0, 17'h05555, "R2");

        // Random operands with carry-in forced low
        for (int i = 0; i < 400; i++) begin
            x = W'($urandom); y = W'($urandom);
            run16(x, y, 1'b0, ref16(x, y, 1'b0), "R2");
        end

        // Random operands and carry-in
        for (int i = 0; i < 1500; i++) begin
            x = W'($urandom); y = W'($urandom); c = 1'($urandom);
            run16(x, y, c, ref16(x, y, c), "R1");
        end

        // Operand pairs that propagate in every column: whole-chain carry path
        for (int i = 0; i < 200; i++) begin
            x = W'($urandom); c = 1'($urandom);
            run16(x, ~x, c, {c, {W{~c}}}, "R4");
        end

        // Top column generating with random lower bits
        for (int i = 0; i < 200; i++) begin
            x = W'($urandom) | 16'h8000; y = W'($urandom) | 16'h8000; c = 1'($urandom);
            run16(x, y, c, ref16(x, y, c), "R6");
            checks++;
            if (co !== 1'b1) begin
                errors++;
                $display("FAIL R6: a=%h b=%h actual=%0b expected=1", x, y, co);
            end
        end

        // Exhaustive sweep of the 4-bit instance
        for (int i = 0; i < 512; i++) begin
            run4(WS'(i), WS'(i >> WS), 1'((i >> (2 * WS)) & 1));
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule